// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the memory-mapped front end that sits between a 32-bit register request port and an interrupt arbiter. Each request carries a word address. The block decodes that address into one of four windows. The first holds one priority register per source. The second is a read-only view of the arbiter's pending bits. The third holds per-context enable words. The fourth is a per-context control window with a threshold register and a claim/complete register. Priorities, enables and thresholds are stored here and presented to the arbiter as flat vectors. The pending bits and each context's current best source ID come back from the arbiter as inputs.

Reading a context's claim/complete register returns that context's best source ID and sends a one-cycle claim strobe to the arbiter. Writing the register sends a one-cycle complete strobe that carries the written ID. Every accepted request receives exactly one response on the next cycle, with read data and an error flag. The request port stays not-ready while a response is out. This spacing gives the arbiter a cycle to retire a claim before the next claim can read its output.

Enable blocks and control blocks are laid out with power-of-two strides. A stride that is not a power of two stops elaboration.

Top module: `irq_reg_frontend`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. One cycle later `resp_valid` is high for exactly one cycle. `req_ready` is low during that cycle, so a request held through it is neither accepted nor answered.
- R2: An access whose address bits [1:0] are not 00 returns `resp_err`=1 and read data 0. It changes no register and raises no claim or complete strobe.
- R3: The priority window starts at PRIO_BASE and gives 4 bytes to each source, so source = (addr-PRIO_BASE)/4. A write keeps the low PRIO_W bits of the data, and a read returns them zero-extended. Source s drives `prio_o[s*PRIO_W +: PRIO_W]`.
- R4: The pending window starts at PEND_BASE. Bit n of word k (at PEND_BASE+4k) is `pend_i[32k+n]`, and bits above the last source read as 0. A write to this window returns `resp_err`=1 and changes nothing.
- R5: For the enable window, off=addr-EN_BASE. The context is off/EN_STRIDE and the word is (off mod EN_STRIDE)/4. Bit n of word k enables source 32k+n and drives `en_o[ctx*N_SRC + 32k+n]`, and bits above the last source read as 0. A word index of ceil(N_SRC/32) or more returns `resp_err`=1, read data 0 and no write.
- R6: For the control window, off=addr-CTX_BASE and the context is off/CTX_STRIDE. Offset 0 within the stride is the threshold, which drives `thr_o[ctx*PRIO_W +: PRIO_W]`. A threshold write with a value above N_PRIO is ignored without error. Any offset other than 0 or 4 returns `resp_err`=1.
- R7: A read at offset 4 returns `claim_id_i[ctx*SRC_IW +: SRC_IW]` as sampled at acceptance. In the response cycle `claim_o` is high with `claim_ctx_o`=ctx, and it is low in the cycle after.
- R8: A write at offset 4 with a value below N_SRC pulses `cmpl_o` for one cycle in the response cycle, with `cmpl_ctx_o`=ctx and `cmpl_id_o`=value. A value of N_SRC or more raises no strobe and no error.
- R9: An aligned address outside all four windows returns `resp_err`=1 and read data 0.
- R10: After reset all priorities, enables and thresholds are 0. `resp_valid`, `claim_o` and `cmpl_o` are low, and `req_ready` is high.
- R11: A successful write returns `resp_err`=0 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response present for one cycle |
| resp_rdata | output | 32 | Read data, 0 for writes and errors |
| resp_err | output | 1 | Access rejected |
| pend_i | input | N_SRC | Pending bits from the arbiter |
| claim_id_i | input | N_CTX*SRC_IW | Best source ID per context from the arbiter |
| prio_o | output | N_SRC*PRIO_W | Source priorities |
| en_o | output | N_CTX*N_SRC | Per-context enable bits |
| thr_o | output | N_CTX*PRIO_W | Per-context thresholds |
| claim_o | output | 1 | One-cycle claim strobe |
| claim_ctx_o | output | CTX_IW | Context of the claim |
| cmpl_o | output | 1 | One-cycle complete strobe |
| cmpl_ctx_o | output | CTX_IW | Context of the complete |
| cmpl_id_o | output | SRC_IW | Source ID being completed |

## Verification
The assertions check several properties on every cycle. Each accepted request is answered once in the next cycle. Misaligned accesses come back as errors with no strobe, and writes into the pending window are flagged. Thresholds never exceed N_PRIO, and a claim strobe never lasts two cycles. A complete never carries an ID out of range. Priority and enable state holds whenever no write is aimed at it. Only the bench scenarios can show that addresses map to the right source, word and context through both strides. They also show that read data matches the arbiter inputs, that out-of-range threshold and complete writes are dropped silently, and that a request held while not ready causes no second claim.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PRIO,
    RG_PEND,
    RG_EN,
    RG_THR,
    RG_CLAIM
  } region_e;
endpackage

// File: rtl/irq_fe_decode.sv
module irq_fe_decode
  import irq_fe_pkg::*;
#(
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h1000,
  parameter int unsigned N_SRC      = 40,
  parameter int unsigned N_CTX      = 2,
  parameter int unsigned EN_WORDS   = 2,
  parameter int unsigned SRC_IW     = 6,
  parameter int unsigned PW_IW      = 1,
  parameter int unsigned CTX_IW     = 1
) (
  input  logic [WORD_W-1:0] addr,
  output region_e           region,
  output logic              err,
  output logic [SRC_IW-1:0] src_idx,
  output logic [PW_IW-1:0]  word_idx,
  output logic [CTX_IW-1:0] ctx_idx
);
  localparam int unsigned PRIO_LEN = N_SRC * 4;
  localparam int unsigned PEND_LEN = EN_WORDS * 4;
  localparam int unsigned EN_LEN   = N_CTX * EN_STRIDE;
  localparam int unsigned CTX_LEN  = N_CTX * CTX_STRIDE;
  localparam int unsigned EN_SH    = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH   = $clog2(CTX_STRIDE);

  logic [WORD_W-1:0] off_p, off_d, off_e, off_c, e_sub, c_sub;

  // Offsets wrap when addr is below a base, so one unsigned compare bounds each window.
  assign off_p = addr - PRIO_BASE;
  assign off_d = addr - PEND_BASE;
  assign off_e = addr - EN_BASE;
  assign off_c = addr - CTX_BASE;
  assign e_sub = off_e & (EN_STRIDE - 1);
  assign c_sub = off_c & (CTX_STRIDE - 1);

  always_comb begin
    region   = RG_NONE;
    err      = 1'b1;
    src_idx  = off_p[SRC_IW+1:2];
    word_idx = '0;
    ctx_idx  = '0;
    if (addr[1:0] != 2'b00) begin
      region = RG_NONE;
    end else if (off_p < PRIO_LEN) begin
      region = RG_PRIO;
      err    = 1'b0;
    end else if (off_d < PEND_LEN) begin
      region   = RG_PEND;
      err      = 1'b0;
      word_idx = off_d[PW_IW+1:2];
    end else if (off_e < EN_LEN) begin
      region   = RG_EN;
      ctx_idx  = off_e[EN_SH +: CTX_IW];
      word_idx = e_sub[PW_IW+1:2];
      err      = (e_sub >> 2) >= EN_WORDS;
    end else if (off_c < CTX_LEN) begin
      ctx_idx = off_c[CTX_SH +: CTX_IW];
      if (c_sub == 32'd0) begin
        region = RG_THR;
        err    = 1'b0;
      end else if (c_sub == 32'd4) begin
        region = RG_CLAIM;
        err    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_fe_src_regs.sv
module irq_fe_src_regs
  import irq_fe_pkg::*;
#(
  parameter int unsigned N_SRC    = 40,
  parameter int unsigned N_CTX    = 2,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned EN_WORDS = 2,
  parameter int unsigned SRC_IW   = 6,
  parameter int unsigned PW_IW    = 1,
  parameter int unsigned CTX_IW   = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     prio_we,
  input  logic                     en_we,
  input  logic [SRC_IW-1:0]        src_idx,
  input  logic [CTX_IW-1:0]        ctx_idx,
  input  logic [PW_IW-1:0]         word_idx,
  input  logic [WORD_W-1:0]        wdata,
  output logic [N_SRC*PRIO_W-1:0]  prio_flat,
  output logic [N_CTX*N_SRC-1:0]   en_flat,
  output logic [PRIO_W-1:0]        prio_rd,
  output logic [WORD_W-1:0]        en_rd
);
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [N_SRC-1:0]  en_q   [N_CTX];
  logic [EN_WORDS*WORD_W-1:0] en_pad;

  for (genvar s = 0; s < N_SRC; s++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[s] <= '0;
      else if (prio_we && src_idx == SRC_IW'(s)) prio_q[s] <= wdata[PRIO_W-1:0];
    end
    assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
  end

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    for (genvar s = 0; s < N_SRC; s++) begin : g_bit
      localparam int unsigned WSEL = s / 32;
      localparam int unsigned BSEL = s % 32;
      always_ff @(posedge clk) begin
        if (rst) en_q[c][s] <= 1'b0;
        else if (en_we && ctx_idx == CTX_IW'(c) && word_idx == PW_IW'(WSEL))
          en_q[c][s] <= wdata[BSEL];
      end
    end
    assign en_flat[c*N_SRC +: N_SRC] = en_q[c];
  end

  assign prio_rd = prio_q[src_idx];

  always_comb begin
    en_pad = '0;
    en_pad[N_SRC-1:0] = en_q[ctx_idx];
  end
  assign en_rd = en_pad[word_idx*WORD_W +: WORD_W];

  // State moves only when a write is aimed at it.
  assert_prio_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !prio_we |=> $stable(prio_flat));
  assert_en_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !en_we |=> $stable(en_flat));
endmodule

// File: rtl/irq_fe_ctx_regs.sv
module irq_fe_ctx_regs
  import irq_fe_pkg::*;
#(
  parameter int unsigned N_SRC  = 40,
  parameter int unsigned N_CTX  = 2,
  parameter int unsigned N_PRIO = 7,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned SRC_IW = 6,
  parameter int unsigned CTX_IW = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     thr_we,
  input  logic                     claim_go,
  input  logic                     cmpl_go,
  input  logic [CTX_IW-1:0]        ctx_idx,
  input  logic [WORD_W-1:0]        wdata,
  output logic [N_CTX*PRIO_W-1:0]  thr_flat,
  output logic [PRIO_W-1:0]        thr_rd,
  output logic                     claim_o,
  output logic [CTX_IW-1:0]        claim_ctx_o,
  output logic                     cmpl_o,
  output logic [CTX_IW-1:0]        cmpl_ctx_o,
  output logic [SRC_IW-1:0]        cmpl_id_o
);
  logic [PRIO_W-1:0] thr_q [N_CTX];
  logic thr_ok, id_ok;

  assign thr_ok = wdata <= N_PRIO;
  assign id_ok  = wdata < N_SRC;

  for (genvar c = 0; c < N_CTX; c++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) thr_q[c] <= '0;
      else if (thr_we && thr_ok && ctx_idx == CTX_IW'(c)) thr_q[c] <= wdata[PRIO_W-1:0];
    end
    assign thr_flat[c*PRIO_W +: PRIO_W] = thr_q[c];

    assert_thr_bound_R6: assert property (@(posedge clk) disable iff (rst)
      32'(thr_q[c]) <= N_PRIO);
  end

  assign thr_rd = thr_q[ctx_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_o     <= 1'b0;
      claim_ctx_o <= '0;
      cmpl_o      <= 1'b0;
      cmpl_ctx_o  <= '0;
      cmpl_id_o   <= '0;
    end else begin
      claim_o <= claim_go;
      cmpl_o  <= cmpl_go && id_ok;
      if (claim_go) claim_ctx_o <= ctx_idx;
      if (cmpl_go && id_ok) begin
        cmpl_ctx_o <= ctx_idx;
        cmpl_id_o  <= wdata[SRC_IW-1:0];
      end
    end
  end

  assert_claim_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    claim_o |=> !claim_o);
  assert_cmpl_range_R8: assert property (@(posedge clk) disable iff (rst)
    cmpl_o |-> (32'(cmpl_id_o) < N_SRC));
  assert_cmpl_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cmpl_o |=> !cmpl_o);
endmodule

// File: rtl/irq_reg_frontend.sv
module irq_reg_frontend
  import irq_fe_pkg::*;
#(
  parameter int unsigned N_SRC      = 40,
  parameter int unsigned N_CTX      = 2,
  parameter int unsigned N_PRIO     = 7,
  parameter int unsigned PRIO_BASE  = 32'h0000,
  parameter int unsigned PEND_BASE  = 32'h1000,
  parameter int unsigned EN_BASE    = 32'h2000,
  parameter int unsigned EN_STRIDE  = 32'h80,
  parameter int unsigned CTX_BASE   = 32'h4000,
  parameter int unsigned CTX_STRIDE = 32'h1000,
  localparam int unsigned PRIO_W    = $clog2(N_PRIO + 1),
  localparam int unsigned SRC_IW    = $clog2(N_SRC),
  localparam int unsigned CTX_IW    = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [31:0]              req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     resp_valid,
  output logic [31:0]              resp_rdata,
  output logic                     resp_err,
  input  logic [N_SRC-1:0]         pend_i,
  input  logic [N_CTX*SRC_IW-1:0]  claim_id_i,
  output logic [N_SRC*PRIO_W-1:0]  prio_o,
  output logic [N_CTX*N_SRC-1:0]   en_o,
  output logic [N_CTX*PRIO_W-1:0]  thr_o,
  output logic                     claim_o,
  output logic [CTX_IW-1:0]        claim_ctx_o,
  output logic                     cmpl_o,
  output logic [CTX_IW-1:0]        cmpl_ctx_o,
  output logic [SRC_IW-1:0]        cmpl_id_o
);
  localparam int unsigned EN_WORDS = (N_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned PW_IW    = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int unsigned PEND_LEN = EN_WORDS * 4;

  if ((EN_STRIDE & (EN_STRIDE - 1)) != 0 || EN_STRIDE < 4 * EN_WORDS) begin : g_bad_en
    $error("enable stride must be a power of two covering all enable words");
  end
  if ((CTX_STRIDE & (CTX_STRIDE - 1)) != 0 || CTX_STRIDE < 8) begin : g_bad_ctx
    $error("context stride must be a power of two of at least 8");
  end

  region_e           region;
  logic              dec_err, acc, rsp_err, wr_ok, rd_ok;
  logic [SRC_IW-1:0] src_idx;
  logic [PW_IW-1:0]  word_idx;
  logic [CTX_IW-1:0] ctx_idx;
  logic [PRIO_W-1:0] prio_rd, thr_rd;
  logic [31:0]       en_rd, rd_val;
  logic [EN_WORDS*WORD_W-1:0] pend_pad;

  irq_fe_decode #(
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
    .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
    .N_SRC(N_SRC), .N_CTX(N_CTX), .EN_WORDS(EN_WORDS),
    .SRC_IW(SRC_IW), .PW_IW(PW_IW), .CTX_IW(CTX_IW)
  ) u_dec (
    .addr(req_addr), .region(region), .err(dec_err),
    .src_idx(src_idx), .word_idx(word_idx), .ctx_idx(ctx_idx)
  );

  // One request in flight: the cycle a response is out, no new request enters.
  assign req_ready = !resp_valid;
  assign acc       = req_valid && req_ready;
  assign rsp_err   = dec_err || (req_write && region == RG_PEND);
  assign wr_ok     = acc && req_write && !dec_err;
  assign rd_ok     = acc && !req_write && !dec_err;

  irq_fe_src_regs #(
    .N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W), .EN_WORDS(EN_WORDS),
    .SRC_IW(SRC_IW), .PW_IW(PW_IW), .CTX_IW(CTX_IW)
  ) u_src (
    .clk(clk), .rst(rst),
    .prio_we(wr_ok && region == RG_PRIO),
    .en_we(wr_ok && region == RG_EN),
    .src_idx(src_idx), .ctx_idx(ctx_idx), .word_idx(word_idx), .wdata(req_wdata),
    .prio_flat(prio_o), .en_flat(en_o), .prio_rd(prio_rd), .en_rd(en_rd)
  );

  irq_fe_ctx_regs #(
    .N_SRC(N_SRC), .N_CTX(N_CTX), .N_PRIO(N_PRIO), .PRIO_W(PRIO_W),
    .SRC_IW(SRC_IW), .CTX_IW(CTX_IW)
  ) u_ctx (
    .clk(clk), .rst(rst),
    .thr_we(wr_ok && region == RG_THR),
    .claim_go(rd_ok && region == RG_CLAIM),
    .cmpl_go(wr_ok && region == RG_CLAIM),
    .ctx_idx(ctx_idx), .wdata(req_wdata),
    .thr_flat(thr_o), .thr_rd(thr_rd),
    .claim_o(claim_o), .claim_ctx_o(claim_ctx_o),
    .cmpl_o(cmpl_o), .cmpl_ctx_o(cmpl_ctx_o), .cmpl_id_o(cmpl_id_o)
  );

  always_comb begin
    pend_pad = '0;
    pend_pad[N_SRC-1:0] = pend_i;
    rd_val = '0;
    case (region)
      RG_PRIO:  rd_val = 32'(prio_rd);
      RG_PEND:  rd_val = pend_pad[word_idx*WORD_W +: WORD_W];
      RG_EN:    rd_val = en_rd;
      RG_THR:   rd_val = 32'(thr_rd);
      RG_CLAIM: rd_val = 32'(claim_id_i[ctx_idx*SRC_IW +: SRC_IW]);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= acc;
      if (acc) begin
        resp_err   <= rsp_err;
        resp_rdata <= (req_write || rsp_err) ? '0 : rd_val;
      end
    end
  end

  assert_one_response_R1: assert property (@(posedge clk) disable iff (rst)
    acc |=> resp_valid);
  assert_single_beat_R1: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
  assert_misaligned_err_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && req_addr[1:0] != 2'b00) |=>
      (resp_valid && resp_err && resp_rdata == '0 && !claim_o && !cmpl_o));
  assert_pend_write_err_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && (req_addr - PEND_BASE) < PEND_LEN) |=> resp_err);
endmodule

// File: tb/irq_reg_frontend_test.sv
module irq_reg_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned NS = 40, NC = 2, NP = 7;
  localparam int unsigned PB = 32'h0000, DB = 32'h1000, EB = 32'h2000, ES = 32'h80;
  localparam int unsigned CB = 32'h4000, CS = 32'h1000;
  localparam int PW = 3, IW = 6, CW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [NS-1:0] pend_i = 40'hA5_1234_5678;
  logic [NC*IW-1:0] claim_id_i = {6'd33, 6'd17};
  logic [NS*PW-1:0] prio_o;
  logic [NC*NS-1:0] en_o;
  logic [NC*PW-1:0] thr_o;
  logic claim_o, cmpl_o;
  logic [CW-1:0] claim_ctx_o, cmpl_ctx_o;
  logic [IW-1:0] cmpl_id_o;

  int n_checks = 0, n_err = 0;
  bit done = 0;
  logic [31:0] g_data;
  logic g_vld, g_err, g_rdy, g_claim, g_cmpl, n_vld, n_rdy, n_claim, n_cmpl;
  logic [CW-1:0] g_cctx, g_kctx;
  logic [IW-1:0] g_kid;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_reg_frontend uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
    .pend_i(pend_i), .claim_id_i(claim_id_i), .prio_o(prio_o), .en_o(en_o),
    .thr_o(thr_o), .claim_o(claim_o), .claim_ctx_o(claim_ctx_o),
    .cmpl_o(cmpl_o), .cmpl_ctx_o(cmpl_ctx_o), .cmpl_id_o(cmpl_id_o)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // One transaction: drive at a falling edge, read the response one cycle later, then the cycle after.
  task automatic xact(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    g_vld = resp_valid; g_data = resp_rdata; g_err = resp_err; g_rdy = req_ready;
    g_claim = claim_o; g_cctx = claim_ctx_o; g_cmpl = cmpl_o; g_kctx = cmpl_ctx_o; g_kid = cmpl_id_o;
    req_valid = 1'b0;
    @(negedge clk);
    n_vld = resp_valid; n_rdy = req_ready; n_claim = claim_o; n_cmpl = cmpl_o;
  endtask

  task automatic t_reset;
    chk("R10 resp_valid after reset", resp_valid, 0);
    chk("R10 req_ready after reset", req_ready, 1);
    chk("R10 prio_o after reset", 32'(prio_o == '0), 1);
    chk("R10 en_o after reset", 32'(en_o == '0), 1);
    chk("R10 thr_o after reset", thr_o, 0);
    chk("R10 strobes after reset", {claim_o, cmpl_o}, 0);
  endtask

  task automatic t_priority;
    xact(1, PB + 5*4, 32'hFFFF_FFFD);
    chk("R1 response valid", g_vld, 1); chk("R1 ready low in response", g_rdy, 0);
    chk("R1 single beat", n_vld, 0); chk("R1 ready back", n_rdy, 1);
    chk("R11 write err", g_err, 0); chk("R11 write data", g_data, 0);
    chk("R3 prio_o src5", prio_o[5*PW +: PW], 5);
    xact(0, PB + 5*4, 0);    chk("R3 read src5", g_data, 5);
    xact(1, PB + 39*4, 2);   xact(0, PB + 39*4, 0);
    chk("R3 read src39", g_data, 2); chk("R3 prio_o src39", prio_o[39*PW +: PW], 2);
    xact(0, PB, 0);          chk("R3 read src0", g_data, 0); chk("R3 src0 err", g_err, 0);
  endtask

  task automatic t_pending;
    xact(0, DB, 0);     chk("R4 pending word0", g_data, 32'h1234_5678);
    xact(0, DB + 4, 0); chk("R4 pending word1", g_data, 32'h0000_00A5);
    xact(1, DB, 32'hFFFF_FFFF);
    chk("R4 pending write err", g_err, 1); chk("R4 no strobe", {g_claim, g_cmpl}, 0);
    chk("R4 state untouched", 32'(en_o == '0), 1);
    xact(0, DB, 0);     chk("R4 pending after write", g_data, 32'h1234_5678);
    xact(0, DB + 8, 0); chk("R9 past pending err", g_err, 1); chk("R9 past pending data", g_data, 0);
  endtask

  task automatic t_enable;
    xact(1, EB + ES + 4, 32'hFFFF_FFFF);
    xact(0, EB + ES + 4, 0); chk("R5 ctx1 word1 read", g_data, 32'h0000_00FF);
    chk("R5 en_o ctx1 src32..39", en_o[NS + 32 +: 8], 8'hFF);
    chk("R5 en_o ctx1 src0..31", en_o[NS +: 32], 0);
    xact(1, EB, 32'h0000_F00F);
    xact(0, EB, 0);          chk("R5 ctx0 word0 read", g_data, 32'h0000_F00F);
    chk("R5 en_o ctx0", en_o[0 +: 32], 32'h0000_F00F);
    xact(0, EB + ES, 0);     chk("R5 ctx1 word0 read", g_data, 0);
    xact(0, EB + 8, 0);      chk("R5 word2 err", g_err, 1); chk("R5 word2 data", g_data, 0);
    xact(1, EB + 8, 32'hFFFF_FFFF);
    chk("R5 word2 write err", g_err, 1);
    chk("R5 word2 write no change", en_o[0 +: 32], 32'h0000_F00F);
  endtask

  task automatic t_threshold;
    xact(1, CB + CS, 5);  chk("R6 thr write err", g_err, 0);
    chk("R6 thr_o ctx1", thr_o[PW +: PW], 5);
    xact(0, CB + CS, 0);  chk("R6 thr read ctx1", g_data, 5);
    xact(1, CB + CS, 9);  chk("R6 thr over max no err", g_err, 0);
    xact(0, CB + CS, 0);  chk("R6 thr over max ignored", g_data, 5);
    xact(1, CB + CS, NP); chk("R6 thr at max", thr_o[PW +: PW], NP);
    xact(1, CB + CS, 5);
    xact(0, CB, 0);       chk("R6 thr ctx0 untouched", g_data, 0);
    xact(0, CB + 8, 0);   chk("R6 bad control offset err", g_err, 1);
  endtask

  task automatic t_claim;
    xact(0, CB + CS + 4, 0);
    chk("R7 claim data ctx1", g_data, 33); chk("R7 claim strobe", g_claim, 1);
    chk("R7 claim ctx", g_cctx, 1);        chk("R7 claim one cycle", n_claim, 0);
    xact(0, CB + 4, 0);
    chk("R7 claim data ctx0", g_data, 17); chk("R7 claim ctx0", g_cctx, 0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = CB + CS + 4;
    @(negedge clk);
    chk("R7 stalled first claim", claim_o, 1);
    chk("R1 not ready while responding", req_ready, 0);
    @(negedge clk);
    chk("R1 held request not answered", resp_valid, 0);
    chk("R7 held request no second claim", claim_o, 0);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_complete;
    xact(1, CB + 4, 12);
    chk("R8 complete strobe", g_cmpl, 1); chk("R8 complete ctx", g_kctx, 0);
    chk("R8 complete id", g_kid, 12);     chk("R8 complete one cycle", n_cmpl, 0);
    chk("R8 complete no claim", g_claim, 0);
    xact(1, CB + CS + 4, NS);
    chk("R8 out-of-range id no strobe", g_cmpl, 0); chk("R8 out-of-range no err", g_err, 0);
    xact(1, CB + CS + 4, NS - 1);
    chk("R8 last id ctx", g_kctx, 1); chk("R8 last id", g_kid, NS - 1);
  endtask

  task automatic t_misaligned;
    xact(0, PB + 5*4 + 1, 0);
    chk("R2 misaligned read err", g_err, 1); chk("R2 misaligned read data", g_data, 0);
    xact(1, CB + CS + 2, 3);
    chk("R2 misaligned write err", g_err, 1); chk("R2 threshold unchanged", thr_o[PW +: PW], 5);
    xact(0, CB + CS + 5, 0);
    chk("R2 misaligned claim no strobe", g_claim, 0); chk("R2 misaligned claim err", g_err, 1);
  endtask

  task automatic t_outside;
    xact(0, 32'h8000, 0);
    chk("R9 outside err", g_err, 1); chk("R9 outside data", g_data, 0);
    xact(1, 32'h0000_3000, 32'h1);
    chk("R9 outside write err", g_err, 1);
    xact(0, PB + NS*4, 0); chk("R9 after priority window err", g_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_priority();
    t_pending();
    t_enable();
    t_threshold();
    t_claim();
    t_stall();
    t_complete();
    t_misaligned();
    t_outside();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule